// File: doc/BRIEF.md
# Wrapping Burst Read Address Sequencer

This block produces the word addresses for a synchronous burst read from a memory that is 16 bits wide and addressed in words. A one-cycle start pulse loads a starting word address and a burst mode. From then on, each clock in which the consumer raises the advance strobe yields one address on `addr_out`, together with a valid flag and a last-word flag.

A burst runs in one of two ways. A wrapped burst covers a short or a long aligned group, 8 or 16 words by default. It begins at the requested word and climbs to the top of its group. It then wraps to the bottom of the same group and ends on the word just below where it started. A linear burst counts upward with no boundary, rolling over at the top of the address space, and runs until the host raises the stop input.

A start pulse that arrives during a burst abandons that burst and reloads the sequencer at once. The block only generates addresses. Decoding, latency counting and the memory itself sit outside it.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, `addr_out` is 0 and both `addr_valid` and `addr_last` are 0.
- R2: At the clock edge where `start` is high, `addr_valid` and `addr_last` go to 0 and `start_addr` and `start_mode` are captured. An advance in that same cycle is ignored. The next advance emits `start_addr` itself.
- R3: Mode codes 2'b00 and 2'b11 select a linear burst. Each advance emits the previous address plus one, rolling over from all ones to zero. `addr_last` is never set.
- R4: Mode code 2'b01 selects the short wrap of 8 words. Only address bits [2:0] change, and they step by one modulo 8. The upper bits equal those of `start_addr`. Exactly 8 valid words are produced.
- R5: Mode code 2'b10 selects the long wrap of 16 words. Only address bits [3:0] change, and they step by one modulo 16. The upper bits equal those of `start_addr`. Exactly 16 valid words are produced.
- R6: `addr_last` is 1 only together with the final word of a wrapped burst. That word's low bits equal the starting low bits minus one, modulo the group size.
- R7: An advance after the final word of a wrapped burst drives `addr_valid` and `addr_last` to 0 and leaves `addr_out` unchanged. Further advances keep `addr_valid` at 0.
- R8: In a cycle where `start`, `stop` and `advance` are all low, `addr_out`, `addr_valid` and `addr_last` keep their values.
- R9: At an edge where `stop` is high and `start` is low, `addr_valid` and `addr_last` go to 0 and the burst ends, so later advances emit nothing. If `start` and `stop` are both high, `start` wins.
- R10: A start pulse in the middle of a burst abandons it. The following advances produce the new burst from its own starting address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Loads a new burst (one-cycle pulse) |
| start_addr | input | ADDR_W | Word address of the first word |
| start_mode | input | 2 | Burst mode: 00 linear, 01 short wrap, 10 long wrap, 11 linear |
| stop | input | 1 | Ends the current burst |
| advance | input | 1 | Consumer requests the next word address |
| addr_out | output | ADDR_W | Emitted word address |
| addr_valid | output | 1 | `addr_out` holds a word of the current burst |
| addr_last | output | 1 | `addr_out` is the final word of a wrapped burst |

## Verification
Both wrap modes are run from every starting address of an 8-bit address space. This separates the words in the group that precede the start from those that follow it, and it exercises starts at the bottom, the middle and the top of a group. The flags are checked one advance past the end of each run to confirm the word count.

Linear bursts start just below the top of the address space in both linear codes, so the rollover and the absence of a wrap boundary show up. Idle gaps, stop pulses, start pulses in the middle of a burst and start coinciding with advance each isolate one priority rule of the sequencer.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

   typedef enum logic [1:0] {
      BM_LINEAR     = 2'b00,
      BM_WRAP_SHORT = 2'b01,
      BM_WRAP_LONG  = 2'b10,
      BM_LINEAR_ALT = 2'b11
   } burst_mode_e;

   function automatic logic is_wrap(input burst_mode_e m);
      return (m == BM_WRAP_SHORT) || (m == BM_WRAP_LONG);
   endfunction

endpackage

// File: rtl/wrap_incr.sv
module wrap_incr
   import burst_seq_pkg::*;
#(
   parameter int ADDR_W     = 24,
   parameter int WRAP_SHORT = 8,
   parameter int WRAP_LONG  = 16
) (
   input  logic [ADDR_W-1:0] cur_addr,
   input  burst_mode_e       mode,
   output logic [ADDR_W-1:0] nxt_addr
);

   localparam int NUM_WRAP = 2;

   logic [ADDR_W-1:0] wrap_cand [NUM_WRAP];
   logic [ADDR_W-1:0] lin_cand;

   assign lin_cand = cur_addr + ADDR_W'(1);

   for (genvar g = 0; g < NUM_WRAP; g++) begin : g_wrap
      localparam int LEN = (g == 0) ? WRAP_SHORT : WRAP_LONG;
      localparam int LB  = $clog2(LEN);
      logic [LB-1:0] low_next;
      assign low_next     = cur_addr[LB-1:0] + LB'(1);
      assign wrap_cand[g] = {cur_addr[ADDR_W-1:LB], low_next};
   end

   always_comb begin
      unique case (mode)
         BM_WRAP_SHORT: nxt_addr = wrap_cand[0];
         BM_WRAP_LONG:  nxt_addr = wrap_cand[1];
         default:       nxt_addr = lin_cand;
      endcase
   end

endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl
   import burst_seq_pkg::*;
#(
   parameter int WRAP_SHORT = 8,
   parameter int WRAP_LONG  = 16
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  burst_mode_e start_mode,
   input  logic        stop,
   input  logic        advance,
   output logic        active,
   output logic        emit,
   output logic        final_word
);

   localparam int CNT_W = $clog2(WRAP_LONG) + 1;

   logic             wrapped;
   logic [CNT_W-1:0] left;

   assign emit       = advance & active & ~start & ~stop;
   assign final_word = wrapped & (left == CNT_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active  <= 1'b0;
         wrapped <= 1'b0;
         left    <= '0;
      end else if (start) begin
         active  <= 1'b1;
         wrapped <= is_wrap(start_mode);
         left    <= (start_mode == BM_WRAP_LONG) ? CNT_W'(WRAP_LONG) : CNT_W'(WRAP_SHORT);
      end else if (stop) begin
         active  <= 1'b0;
      end else if (emit && wrapped) begin
         left <= left - CNT_W'(1);
         if (left == CNT_W'(1)) active <= 1'b0;
      end
   end

   // R4 R5: the remaining-word count of a live wrapped burst stays within the group
   assert_count_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (active && wrapped) |-> (left != '0 && left <= CNT_W'(WRAP_LONG)));

   // R6 R7: emitting the final word of a wrapped burst ends it
   assert_final_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (emit && final_word) |=> !active);

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
   import burst_seq_pkg::*;
#(
   parameter int ADDR_W     = 24,
   parameter int WRAP_SHORT = 8,
   parameter int WRAP_LONG  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [1:0]        start_mode,
   input  logic              stop,
   input  logic              advance,
   output logic [ADDR_W-1:0] addr_out,
   output logic              addr_valid,
   output logic              addr_last
);

   localparam int LB_SHORT = $clog2(WRAP_SHORT);
   localparam int LB_LONG  = $clog2(WRAP_LONG);

   if (WRAP_SHORT < 2 || (1 << LB_SHORT) != WRAP_SHORT)
      $error("WRAP_SHORT must be a power of two of at least 2");
   if ((1 << LB_LONG) != WRAP_LONG || WRAP_LONG <= WRAP_SHORT)
      $error("WRAP_LONG must be a power of two above WRAP_SHORT");
   if (ADDR_W <= LB_LONG || ADDR_W > 32)
      $error("ADDR_W must exceed the long wrap width and not exceed 32");

   burst_mode_e       mode_in;
   burst_mode_e       mode_q;
   logic [ADDR_W-1:0] cur_addr;
   logic [ADDR_W-1:0] nxt_addr;
   logic              active;
   logic              emit;
   logic              final_word;

   assign mode_in = burst_mode_e'(start_mode);

   burst_ctrl #(
      .WRAP_SHORT (WRAP_SHORT),
      .WRAP_LONG  (WRAP_LONG)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .start_mode (mode_in),
      .stop       (stop),
      .advance    (advance),
      .active     (active),
      .emit       (emit),
      .final_word (final_word)
   );

   wrap_incr #(
      .ADDR_W     (ADDR_W),
      .WRAP_SHORT (WRAP_SHORT),
      .WRAP_LONG  (WRAP_LONG)
   ) u_incr (
      .cur_addr (cur_addr),
      .mode     (mode_q),
      .nxt_addr (nxt_addr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_addr   <= '0;
         mode_q     <= BM_LINEAR;
         addr_out   <= '0;
         addr_valid <= 1'b0;
         addr_last  <= 1'b0;
      end else if (start) begin
         cur_addr   <= start_addr;
         mode_q     <= mode_in;
         addr_valid <= 1'b0;
         addr_last  <= 1'b0;
      end else if (stop) begin
         addr_valid <= 1'b0;
         addr_last  <= 1'b0;
      end else if (advance) begin
         if (emit) begin
            addr_out   <= cur_addr;
            cur_addr   <= nxt_addr;
            addr_valid <= 1'b1;
            addr_last  <= final_word;
         end else begin
            addr_valid <= 1'b0;
            addr_last  <= 1'b0;
         end
      end
   end

   // R8: nothing moves in an idle cycle
   assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && !stop && !advance) |=> ($stable(addr_out) && $stable(addr_valid) && $stable(addr_last)));

   // R2: a start pulse clears the output flags
   assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (!addr_valid && !addr_last));

   // R9: stop clears the output flags
   assert_stop_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (stop && !start) |=> (!addr_valid && !addr_last));

   // R6: the last flag never appears without a valid word
   assert_last_has_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
      addr_last |-> addr_valid);

   // R7: advancing past the final word drops valid
   assert_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_last && advance && !start && !stop) |=> !addr_valid);

   // R3: consecutive linear words differ by one
   assert_linear_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (emit && addr_valid && !is_wrap(mode_q)) |=> (addr_out == ADDR_W'($past(addr_out) + 1'b1)));

   // R4 R5: consecutive wrapped words keep the group and step the low bits
   for (genvar g = 0; g < 2; g++) begin : g_wrap_chk
      localparam int          LB   = (g == 0) ? LB_SHORT : LB_LONG;
      localparam burst_mode_e CODE = (g == 0) ? BM_WRAP_SHORT : BM_WRAP_LONG;
      assert_wrap_group_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (emit && addr_valid && mode_q == CODE) |=>
            ((addr_out[ADDR_W-1:LB] == $past(addr_out[ADDR_W-1:LB])) &&
             (addr_out[LB-1:0] == LB'($past(addr_out[LB-1:0]) + 1'b1))));
   end

endmodule

// File: tb/sim_burst_addr_seq.sv
`timescale 1ns/100ps
module sim_burst_addr_seq;

   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] start_addr = '0;
   logic [1:0]    start_mode = 2'b00;
   logic          stop = 1'b0;
   logic          advance = 1'b0;
   logic [AW-1:0] addr_out;
   logic          addr_valid;
   logic          addr_last;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   burst_addr_seq #(.ADDR_W(AW), .WRAP_SHORT(8), .WRAP_LONG(16)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
      .start_mode(start_mode), .stop(stop), .advance(advance),
      .addr_out(addr_out), .addr_valid(addr_valid), .addr_last(addr_last)
   );

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step(input logic st, input logic [AW-1:0] sa, input logic [1:0] md,
                       input logic sp, input logic adv);
      @(negedge clk);
      start = st; start_addr = sa; start_mode = md; stop = sp; advance = adv;
      @(posedge clk);
      #1;
   endtask

   task automatic run_wrap(input int sa, input logic [1:0] md, input int len);
      step(1'b1, AW'(sa), md, 1'b0, 1'b0);
      check("R2 valid after start", addr_valid, 0);
      for (int i = 0; i < len; i++) begin
         step(1'b0, '0, 2'b00, 1'b0, 1'b1);
         check(len == 8 ? "R4 wrap8 addr" : "R5 wrap16 addr", addr_out,
               (sa & ~(len - 1)) | ((sa + i) & (len - 1)));
         check("R4 R5 valid", addr_valid, 1);
         check("R6 last flag", addr_last, (i == len - 1) ? 1 : 0);
      end
      step(1'b0, '0, 2'b00, 1'b0, 1'b1);
      check("R7 valid after end", addr_valid, 0);
      check("R7 last after end", addr_last, 0);
      check("R7 addr held", addr_out, (sa & ~(len - 1)) | ((sa + len - 1) & (len - 1)));
   endtask

   initial begin
      #750000;
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      step(1'b0, '0, 2'b00, 1'b0, 1'b0);
      step(1'b0, '0, 2'b00, 1'b0, 1'b1);
      check("R1 reset addr", addr_out, 0);
      check("R1 reset valid", addr_valid, 0);
      check("R1 reset last", addr_last, 0);
      rst_n = 1'b1;

      // R4 R5 R6 R7: every start address in both wrap sizes
      for (int sa = 0; sa < 256; sa++) begin
         run_wrap(sa, 2'b01, 8);
         run_wrap(sa, 2'b10, 16);
      end

      // R3: linear rollover in both linear codes
      for (int c = 0; c < 2; c++) begin
         step(1'b1, 8'd250, c == 0 ? 2'b00 : 2'b11, 1'b0, 1'b0);
         for (int i = 0; i < 12; i++) begin
            step(1'b0, '0, 2'b00, 1'b0, 1'b1);
            check("R3 linear addr", addr_out, (250 + i) % 256);
            check("R3 linear valid", addr_valid, 1);
            check("R3 linear last", addr_last, 0);
         end
         // R9: stop ends the linear burst
         step(1'b0, '0, 2'b00, 1'b1, 1'b1);
         check("R9 stop valid", addr_valid, 0);
         step(1'b0, '0, 2'b00, 1'b0, 1'b1);
         check("R9 advance after stop", addr_valid, 0);
      end

      // R8: idle cycles hold outputs mid-burst
      step(1'b1, 8'd37, 2'b01, 1'b0, 1'b0);
      step(1'b0, '0, 2'b00, 1'b0, 1'b1);
      step(1'b0, '0, 2'b00, 1'b0, 1'b1);
      for (int i = 0; i < 3; i++) begin
         step(1'b0, '0, 2'b00, 1'b0, 1'b0);
         check("R8 hold addr", addr_out, 38);
         check("R8 hold valid", addr_valid, 1);
      end
      step(1'b0, '0, 2'b00, 1'b0, 1'b1);
      check("R8 resume addr", addr_out, 39);

      // R10: start mid-burst with advance in the same cycle (R2 ignored advance)
      step(1'b1, 8'd100, 2'b10, 1'b0, 1'b1);
      check("R2 R10 valid after restart", addr_valid, 0);
      check("R2 addr not advanced", addr_out, 39);
      for (int i = 0; i < 16; i++) begin
         step(1'b0, '0, 2'b00, 1'b0, 1'b1);
         check("R10 reloaded addr", addr_out, 96 + ((100 - 96 + i) % 16));
         check("R10 last", addr_last, (i == 15) ? 1 : 0);
      end

      // R9: start wins over stop
      step(1'b1, 8'd200, 2'b00, 1'b1, 1'b0);
      step(1'b0, '0, 2'b00, 1'b0, 1'b1);
      check("R9 start beats stop valid", addr_valid, 1);
      check("R9 start beats stop addr", addr_out, 200);
      // R9: stop during a wrapped burst
      step(1'b1, 8'd5, 2'b01, 1'b0, 1'b0);
      step(1'b0, '0, 2'b00, 1'b0, 1'b1);
      step(1'b0, '0, 2'b00, 1'b1, 1'b0);
      check("R9 stop wrap valid", addr_valid, 0);
      step(1'b0, '0, 2'b00, 1'b0, 1'b1);
      check("R9 stop wrap stays", addr_valid, 0);
      check("R9 stop wrap addr held", addr_out, 5);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule